// File: doc/BRIEF.md
# Two-Tier Interrupt Enable Controller

This block gathers interrupt events from two groups of sources, a core group and a peripheral group, and reduces them to one request line toward the CPU. Each source owns a sticky flag and an enable bit. A flag records its event whatever the masks say. The request line rises once some flag has every enable on its path set. Core sources pass through their own enable and the global enable. Peripheral sources must also pass a shared group enable.

Software reaches the flags and enables through a small register port with a combinational read. It can force a flag to 1 to request an interrupt, or write 0 to clear it after servicing. The hardware gives no priority and no vector: the service routine polls the flags in whatever order it chooses. When the CPU acknowledges entry, the global enable clears itself, so further events only collect as flags. A return-from-interrupt sets the global enable again.

Top module: `irq_gate_ctrl`

## Requirements
- R1: A source event pulse sets that source's flag on the next clock edge, whatever the state of its own enable, the group enable and the global enable.
- R2: Register map, with values held in the low bits of the data word: address 0 holds control (bit 0 global enable, bit 1 peripheral-group enable); 1 holds the core enables; 2 the core flags; 3 the peripheral enables; 4 the peripheral flags; bit i maps to source i. A write loads the whole field. Writing 1 to a flag raises a request exactly as an event does, and writing 0 clears it. Unmapped addresses read 0.
- R3: A flag that was set while masked stays pending, and the request rises in the cycle after the write that lifts the last blocking enable.
- R4: A flag cleared before its mask is lifted produces no request when the mask is lifted.
- R5: A peripheral source drives the request only when its flag, its enable, the group enable and the global enable are all 1.
- R6: A core source drives the request when its flag, its enable and the global enable are 1, whatever the state of the group enable.
- R7: Reset clears the global enable, the group enable, every source enable and every flag.
- R8: An entry acknowledge clears the global enable on the next edge, and a return sets it. When these coincide with each other or with a software write to control, the acknowledge wins over the return, and the return wins over the write.
- R9: While the global enable is 0, events only set flags, and the request line stays 0.
- R10: When an event and a software write of 0 hit the same flag in one cycle, the flag ends at 1.
- R11: A repeated event on a source whose flag is already 1 has no further effect: one write of 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_evt_i | input | N_CORE | Set strobes from core sources |
| peri_evt_i | input | N_PERI | Set strobes from peripheral sources |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data (combinational) |
| irq_ack_i | input | 1 | CPU entry acknowledge |
| irq_ret_i | input | 1 | Return-from-interrupt |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The hardest states to reach are same-cycle collisions: an event landing in the very cycle software clears the same flag, and an acknowledge meeting a return or a control write. The bench reaches them by driving the strobe and the write together on one falling edge, then reading back through the register port. The gating itself is swept over every combination of global enable, group enable, source enables and flags in a small configuration, and the request is compared against an arithmetic model.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL      = 3'd0,
    REG_CORE_EN   = 3'd1,
    REG_CORE_FLAG = 3'd2,
    REG_PERI_EN   = 3'd3,
    REG_PERI_FLAG = 3'd4
  } reg_sel_e;

  localparam int unsigned CTRL_GLB_BIT = 0;
  localparam int unsigned CTRL_GRP_BIT = 1;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         flag_we_i,
  input  logic         en_we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] en_o,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] flag_q;
  logic [N-1:0] en_q;

  for (genvar g = 0; g < N; g++) begin : g_src
    // event OR'd after the write mux: a set beats a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[g] <= 1'b0;
      else         flag_q[g] <= evt_i[g] | (flag_we_i ? wdata_i[g] : flag_q[g]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      en_q[g] <= 1'b0;
      else if (en_we_i) en_q[g] <= wdata_i[g];
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign pend_o = flag_q & en_q;
endmodule

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic glb_wdata_i,
  input  logic grp_wdata_i,
  input  logic ack_i,
  input  logic ret_i,
  output logic glb_en_o,
  output logic grp_en_o
);
  logic glb_q, grp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    glb_q <= 1'b0;
    else if (ack_i) glb_q <= 1'b0;
    else if (ret_i) glb_q <= 1'b1;
    else if (we_i)  glb_q <= glb_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   grp_q <= 1'b0;
    else if (we_i) grp_q <= grp_wdata_i;
  end

  assign glb_en_o = glb_q;
  assign grp_en_o = grp_q;
endmodule

// File: rtl/irq_req_merge.sv
module irq_req_merge #(
  parameter int unsigned N_CORE = 2,
  parameter int unsigned N_PERI = 3
) (
  input  logic [N_CORE-1:0] core_pend_i,
  input  logic [N_PERI-1:0] peri_pend_i,
  input  logic              grp_en_i,
  input  logic              glb_en_i,
  output logic              irq_o
);
  logic core_any, peri_any;

  assign core_any = |core_pend_i;
  assign peri_any = grp_en_i & (|peri_pend_i);
  assign irq_o    = glb_en_i & (core_any | peri_any);
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irq_gate_pkg::*;
#(
  parameter int unsigned N_CORE = 2,
  parameter int unsigned N_PERI = 3,
  parameter int unsigned DW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CORE-1:0] core_evt_i,
  input  logic [N_PERI-1:0] peri_evt_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              irq_ack_i,
  input  logic              irq_ret_i,
  output logic              irq_o
);
  reg_sel_e sel;
  logic ctrl_we, core_en_we, core_flag_we, peri_en_we, peri_flag_we;
  logic glb_en, grp_en;
  logic [N_CORE-1:0] core_flag, core_en, core_pend;
  logic [N_PERI-1:0] peri_flag, peri_en, peri_pend;

  assign sel          = reg_sel_e'(reg_addr_i);
  assign ctrl_we      = reg_we_i && (sel == REG_CTRL);
  assign core_en_we   = reg_we_i && (sel == REG_CORE_EN);
  assign core_flag_we = reg_we_i && (sel == REG_CORE_FLAG);
  assign peri_en_we   = reg_we_i && (sel == REG_PERI_EN);
  assign peri_flag_we = reg_we_i && (sel == REG_PERI_FLAG);

  irq_src_bank #(.N(N_CORE)) u_core_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (core_evt_i),
    .flag_we_i(core_flag_we),
    .en_we_i  (core_en_we),
    .wdata_i  (reg_wdata_i[N_CORE-1:0]),
    .flag_o   (core_flag),
    .en_o     (core_en),
    .pend_o   (core_pend)
  );

  irq_src_bank #(.N(N_PERI)) u_peri_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (peri_evt_i),
    .flag_we_i(peri_flag_we),
    .en_we_i  (peri_en_we),
    .wdata_i  (reg_wdata_i[N_PERI-1:0]),
    .flag_o   (peri_flag),
    .en_o     (peri_en),
    .pend_o   (peri_pend)
  );

  irq_enable_ctrl u_en_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (ctrl_we),
    .glb_wdata_i(reg_wdata_i[CTRL_GLB_BIT]),
    .grp_wdata_i(reg_wdata_i[CTRL_GRP_BIT]),
    .ack_i      (irq_ack_i),
    .ret_i      (irq_ret_i),
    .glb_en_o   (glb_en),
    .grp_en_o   (grp_en)
  );

  irq_req_merge #(.N_CORE(N_CORE), .N_PERI(N_PERI)) u_merge (
    .core_pend_i(core_pend),
    .peri_pend_i(peri_pend),
    .grp_en_i   (grp_en),
    .glb_en_i   (glb_en),
    .irq_o      (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (sel)
      REG_CTRL: begin
        reg_rdata_o[CTRL_GLB_BIT] = glb_en;
        reg_rdata_o[CTRL_GRP_BIT] = grp_en;
      end
      REG_CORE_EN:   reg_rdata_o[N_CORE-1:0] = core_en;
      REG_CORE_FLAG: reg_rdata_o[N_CORE-1:0] = core_flag;
      REG_PERI_EN:   reg_rdata_o[N_PERI-1:0] = peri_en;
      REG_PERI_FLAG: reg_rdata_o[N_PERI-1:0] = peri_flag;
      default:       reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk #(
  parameter int unsigned N_CORE = 2,
  parameter int unsigned N_PERI = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_CORE-1:0] core_evt_i,
  input logic [N_PERI-1:0] peri_evt_i,
  input logic              irq_ack_i,
  input logic              irq_ret_i,
  input logic              irq_o,
  input logic              glb_en_i,
  input logic              grp_en_i,
  input logic [N_CORE-1:0] core_flag_i,
  input logic [N_CORE-1:0] core_en_i,
  input logic [N_PERI-1:0] peri_flag_i,
  input logic              core_flag_we_i,
  input logic              peri_flag_we_i
);
  // R1 and R10: an event sets its flag even under a clearing write
  a_r1_core_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|core_evt_i) |=> ((core_flag_i & $past(core_evt_i)) == $past(core_evt_i)));

  a_r10_peri_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|peri_evt_i) |=> ((peri_flag_i & $past(peri_evt_i)) == $past(peri_evt_i)));

  // R11: without a write, set flags stay set
  a_r11_core_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_flag_we_i |=> ((core_flag_i & $past(core_flag_i)) == $past(core_flag_i)));

  a_r11_peri_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !peri_flag_we_i |=> ((peri_flag_i & $past(peri_flag_i)) == $past(peri_flag_i)));

  a_r8_ack_clears_glb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_i |=> !glb_en_i);

  a_r8_ret_sets_glb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ret_i && !irq_ack_i) |=> glb_en_i);

  a_r9_glb_off_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_i |-> !irq_o);

  // R5 / R6: with the group gate closed only core sources can request
  a_r6_grp_off_core_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !grp_en_i) |-> (|(core_flag_i & core_en_i)));
endmodule

bind irq_gate_ctrl irq_gate_chk #(.N_CORE(N_CORE), .N_PERI(N_PERI)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .core_evt_i    (core_evt_i),
  .peri_evt_i    (peri_evt_i),
  .irq_ack_i     (irq_ack_i),
  .irq_ret_i     (irq_ret_i),
  .irq_o         (irq_o),
  .glb_en_i      (glb_en),
  .grp_en_i      (grp_en),
  .core_flag_i   (core_flag),
  .core_en_i     (core_en),
  .peri_flag_i   (peri_flag),
  .core_flag_we_i(core_flag_we),
  .peri_flag_we_i(peri_flag_we)
);

// File: tb/irq_gate_ctrl_bench.sv
`timescale 1ns/1ps
module irq_gate_ctrl_bench;
  localparam int NC = 2;
  localparam int NP = 3;
  localparam int DW = 8;
  localparam logic [2:0] A_CTRL = 3'd0, A_CEN = 3'd1, A_CFL = 3'd2,
                         A_PEN = 3'd3, A_PFL = 3'd4, A_BAD = 3'd6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0] core_evt = '0;
  logic [NP-1:0] peri_evt = '0;
  logic we = 1'b0;
  logic [2:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic ack = 1'b0, ret = 1'b0;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_gate_ctrl #(.N_CORE(NC), .N_PERI(NP), .DW(DW)) u_irq_gate_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .core_evt_i(core_evt), .peri_evt_i(peri_evt),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_ack_i(ack), .irq_ret_i(ret), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input logic [NC-1:0] c, input logic [NP-1:0] p);
    @(negedge clk); core_evt = c; peri_evt = p;
    @(negedge clk); core_evt = '0; peri_evt = '0;
  endtask

  task automatic clear_all();
    wr(A_CTRL, 0); wr(A_CEN, 0); wr(A_CFL, 0); wr(A_PEN, 0); wr(A_PFL, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d); check("R7 reset reg", d, 0);
    end
    check("R7 reset irq", irq, 0);
    rd(A_BAD, d); check("R2 unmapped read", d, 0);

    // R1: events set flags with everything masked
    pulse(2'b01, 3'b100);
    rd(A_CFL, d); check("R1 core flag", d, 8'h01);
    rd(A_PFL, d); check("R1 peri flag", d, 8'h04);
    check("R1 masked no irq", irq, 0);

    // R3: pending core flag fires when last enable opens
    wr(A_CEN, 8'h01);
    check("R3 still masked by glb", irq, 0);
    wr(A_CTRL, 8'h01);
    check("R3 pending core fires", irq, 1);
    clear_all();

    // R4: flag cleared while group gate closed never requests
    wr(A_CTRL, 8'h01); wr(A_PEN, 8'h04);
    pulse(0, 3'b100);
    check("R5 group closed", irq, 0);
    wr(A_PFL, 0);
    wr(A_CTRL, 8'h03);
    check("R4 cleared flag silent", irq, 0);
    // R3: same path, flag kept, then gate opens
    wr(A_CTRL, 8'h01);
    pulse(0, 3'b100);
    check("R3 pending peri held", irq, 0);
    wr(A_CTRL, 8'h03);
    check("R3 pending peri fires", irq, 1);
    clear_all();

    // R9 / R8: global off collects flags only; return re-enables
    wr(A_CEN, 8'h02);
    pulse(2'b10, 0);
    rd(A_CFL, d); check("R9 flag set while glb off", d, 8'h02);
    check("R9 no irq while glb off", irq, 0);
    @(negedge clk); ret = 1'b1; @(negedge clk); ret = 1'b0;
    rd(A_CTRL, d); check("R8 ret sets glb", d, 8'h01);
    check("R8 irq after ret", irq, 1);
    @(negedge clk); ack = 1'b1; @(negedge clk); ack = 1'b0;
    rd(A_CTRL, d); check("R8 ack clears glb", d, 8'h00);
    check("R8 irq dropped on ack", irq, 0);
    // R8: ack wins over ret and over a control write in the same cycle
    @(negedge clk); ack = 1'b1; ret = 1'b1; we = 1'b1; addr = A_CTRL; wdata = 8'h03;
    @(negedge clk); ack = 1'b0; ret = 1'b0; we = 1'b0;
    rd(A_CTRL, d); check("R8 ack beats ret and write", d, 8'h02);
    // R8: ret wins over control write of 0
    @(negedge clk); ret = 1'b1; we = 1'b1; addr = A_CTRL; wdata = 8'h00;
    @(negedge clk); ret = 1'b0; we = 1'b0;
    rd(A_CTRL, d); check("R8 ret beats write", d, 8'h01);
    clear_all();

    // R10: event and clearing write collide
    wr(A_CFL, 8'h03);
    @(negedge clk); core_evt = 2'b01; we = 1'b1; addr = A_CFL; wdata = 8'h00;
    @(negedge clk); core_evt = '0; we = 1'b0;
    rd(A_CFL, d); check("R10 set beats clear", d, 8'h01);
    clear_all();

    // R11: repeated events collapse into one flag
    pulse(0, 3'b010); pulse(0, 3'b010); pulse(0, 3'b010);
    rd(A_PFL, d); check("R11 single flag", d, 8'h02);
    wr(A_PFL, 0);
    rd(A_PFL, d); check("R11 one clear suffices", d, 8'h00);
    clear_all();

    // R2 R5 R6: full sweep of gates, enables and software-forced flags
    for (int v = 0; v < 4096; v++) begin
      logic glb, grp;
      logic [NC-1:0] ce, cf;
      logic [NP-1:0] pe, pf;
      logic exp_irq;
      glb = v[0]; grp = v[1];
      ce = v[3:2]; cf = v[5:4]; pe = v[8:6]; pf = v[11:9];
      wr(A_CTRL, {6'b0, grp, glb});
      wr(A_CEN, {6'b0, ce}); wr(A_CFL, {6'b0, cf});
      wr(A_PEN, {5'b0, pe}); wr(A_PFL, {5'b0, pf});
      exp_irq = glb & ((|(cf & ce)) | (grp & (|(pf & pe))));
      check("R5 R6 gated request", irq, exp_irq);
      if (v[2:0] == 3'b0) begin
        rd(A_CFL, d); check("R2 core flag write", d, {6'b0, cf});
        rd(A_PFL, d); check("R2 peri flag write", d, {5'b0, pf});
      end
    end

    // R7: reset mid-run
    wr(A_CTRL, 8'h03); wr(A_CEN, 8'h03); wr(A_PEN, 8'h07); wr(A_CFL, 8'h03);
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d); check("R7 reset mid-run", d, 0);
    end
    check("R7 irq after reset", irq, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule